// File: doc/BRIEF.md
# Cable Direction Sequencer

This block sets the direction of three bidirectional cable channels. Each channel pairs a line transceiver with a voltage-level translator. The requesting logic device raises one request bit per cable, asking for input or output mode. For each channel the block drives a transceiver direction bit, a translator direction bit and an active-low translator output enable. Each request is synchronised with two flops. A direction change then runs as a fixed sequence. First the translator output is switched off. After an off-wait the two direction bits flip together. After a settle wait the output is switched back on.

A global permission input sits above all of this. While permission is low, every translator output enable is forced to its inactive (high) level at once, whatever the channel state machines are doing. Each channel also reports a busy flag while a switch is in progress.

Each channel runs its own state machine with three states:
- IDLE: output enabled, not busy.
- DRAIN: output disabled while the off-wait is counted.
- SETTLE: output disabled while the settle wait is counted, with the new direction already applied.

The state machine has four transitions:
- `idle_to_drain`: the synchronised request differs from the applied mode. The block latches the requested mode.
- `drain_to_settle`: the off-wait has expired. Both direction bits take the latched mode.
- `settle_to_idle`: the settle wait has expired and no further change is pending.
- `settle_to_drain`: the settle wait has expired, but the newest request already differs again.

Reset places every channel in SETTLE, in input mode.

Top module: `cable_dir_seq`

## Requirements
- R1: The block manages three channels, each with its own transceiver direction, translator direction, output-enable and busy outputs. A request on one channel leaves the outputs of the other channels unchanged.
- R2: Encoding: request 1 means input mode and request 0 means output mode. Direction bit 0 means receive (input) and 1 means transmit (output). A channel's transceiver and translator direction bits are always equal.
- R3: While `permit_i` is low, every bit of `trl_oe_n_o` is 1 in the same cycle, regardless of channel state. When `permit_i` returns high, the enables of idle channels return to 0 in the same cycle.
- R4: During reset and just after it, every direction bit is 0, every enable is 1 and every busy flag is 1. With permission high, the enables go to 0 and busy goes to 0 after the 4th rising clock edge following reset release.
- R5: Each request passes through a two-flop synchroniser. A request change applied before rising edge 1 has no visible effect after edge 2. The channel's enable goes to 1 and busy goes to 1 after edge 3.
- R6: During a switch, the direction bits change only while the enable is already off. They flip 4 cycles after the enable turns off (after edge 7).
- R7: The enable turns back on (to 0) 4 cycles after the direction bits flip (after edge 11), and at no earlier point.
- R8: If the request changes again during a switch, the current switch completes. The channel then goes straight into a new switch toward the newest value, without re-enabling the output in between.
- R9: The busy flag is 1 exactly while a channel is in DRAIN or SETTLE. When busy is 0, the enable equals the inverse of `permit_i`.
- R10: A request equal to the channel's current mode starts no switch: busy stays 0 and the enable stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| permit_i | input | 1 | Global permission; low forces all enables inactive |
| req_input_i | input | NUM_CH | Per-channel request, 1 = input mode, 0 = output mode |
| xcvr_dir_o | output | NUM_CH | Transceiver direction, 1 = transmit |
| trl_dir_o | output | NUM_CH | Translator direction, 1 = transmit |
| trl_oe_n_o | output | NUM_CH | Active-low translator output enable |
| busy_o | output | NUM_CH | Switch in progress |

## Verification
The bench builds the block with its default parameters: three channels, two synchroniser stages, and off-wait and settle waits of four cycles each. These short waits allow every phase edge to be sampled on an exact, hand-counted cycle. That covers the third-edge reaction after synchronisation, the flip at edge 7 and the re-enable at edge 11. Three channels make it possible to run simultaneous switches and to show that a request on one channel leaves the others alone. The edge counts in the requirements all follow from these default values.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_SETTLE = 2'd2
    } chan_state_e;

    function automatic int unsigned larger_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdir_sync.sv
module cdir_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= {W{RST_VAL}};
            end
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cdir_chan_fsm.sv
module cdir_chan_fsm
    import cdir_pkg::*;
#(
    parameter int unsigned OFF_WAIT    = 4,
    parameter int unsigned SETTLE_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in_i,     // synchronised, 1 = input mode
    output logic xcvr_dir_o,   // 1 = transmit
    output logic trl_dir_o,    // 1 = transmit
    output logic en_o,         // translator output wanted on
    output logic busy_o
);

    localparam int unsigned LONGEST = larger_of(OFF_WAIT, SETTLE_WAIT);
    localparam int unsigned CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_WAIT - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_WAIT - 1);

    chan_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          mode_in_q, mode_in_d;   // applied mode, 1 = input
    logic          tgt_in_q, tgt_in_d;     // mode latched at switch start

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SETTLE;
            cnt_q     <= '0;
            mode_in_q <= 1'b1;
            tgt_in_q  <= 1'b1;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            mode_in_q <= mode_in_d;
            tgt_in_q  <= tgt_in_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        mode_in_d = mode_in_q;
        tgt_in_d  = tgt_in_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_in_i != mode_in_q) begin        // idle_to_drain
                    state_d  = ST_DRAIN;
                    cnt_d    = '0;
                    tgt_in_d = req_in_i;
                end
            end
            ST_DRAIN: begin
                if (cnt_q == OFF_LAST) begin            // drain_to_settle
                    state_d   = ST_SETTLE;
                    cnt_d     = '0;
                    mode_in_d = tgt_in_q;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SET_LAST) begin
                    cnt_d = '0;
                    if (req_in_i != mode_in_q) begin    // settle_to_drain
                        state_d  = ST_DRAIN;
                        tgt_in_d = req_in_i;
                    end else begin                      // settle_to_idle
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_SETTLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        xcvr_dir_o = ~mode_in_q;
        trl_dir_o  = ~mode_in_q;
        en_o       = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                en_o   = 1'b1;
                busy_o = 1'b0;
            end
            ST_DRAIN, ST_SETTLE: begin
                en_o   = 1'b0;
                busy_o = 1'b1;
            end
            default: begin
                en_o   = 1'b0;
                busy_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cdir_oe_gate.sv
module cdir_oe_gate #(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              permit_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic [NUM_CH-1:0] oe_n_o
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
        assign oe_n_o[g] = ~(en_i[g] & permit_i);
    end

endmodule

// File: rtl/cable_dir_seq.sv
module cable_dir_seq #(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFF_WAIT    = 4,
    parameter int unsigned SETTLE_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              permit_i,
    input  logic [NUM_CH-1:0] req_input_i,
    output logic [NUM_CH-1:0] xcvr_dir_o,
    output logic [NUM_CH-1:0] trl_dir_o,
    output logic [NUM_CH-1:0] trl_oe_n_o,
    output logic [NUM_CH-1:0] busy_o
);

    logic [NUM_CH-1:0] req_sync;
    logic [NUM_CH-1:0] chan_en;

    cdir_sync #(
        .W       (NUM_CH),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_input_i),
        .q_o   (req_sync)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        cdir_chan_fsm #(
            .OFF_WAIT    (OFF_WAIT),
            .SETTLE_WAIT (SETTLE_WAIT)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_in_i   (req_sync[c]),
            .xcvr_dir_o (xcvr_dir_o[c]),
            .trl_dir_o  (trl_dir_o[c]),
            .en_o       (chan_en[c]),
            .busy_o     (busy_o[c])
        );
    end

    cdir_oe_gate #(
        .NUM_CH (NUM_CH)
    ) u_gate (
        .permit_i (permit_i),
        .en_i     (chan_en),
        .oe_n_o   (trl_oe_n_o)
    );

endmodule

// File: rtl/cable_dir_seq_chk.sv
module cable_dir_seq_chk #(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned SETTLE_WAIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              permit_i,
    input logic [NUM_CH-1:0] xcvr_dir_o,
    input logic [NUM_CH-1:0] trl_dir_o,
    input logic [NUM_CH-1:0] trl_oe_n_o,
    input logic [NUM_CH-1:0] busy_o
);

    logic [NUM_CH-1:0] prev_dir_q;
    int unsigned       since_q [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_dir_q <= '0;
        else        prev_dir_q <= xcvr_dir_o;
    end

    // R3: permission low forces every enable inactive
    assert_permit_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !permit_i |-> (&trl_oe_n_o));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          since_q[c] <= SETTLE_WAIT;
            else if (xcvr_dir_o[c] != prev_dir_q[c]) since_q[c] <= 0;
            else if (since_q[c] < SETTLE_WAIT)   since_q[c] <= since_q[c] + 1;
        end

        assert_dirs_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
            xcvr_dir_o[c] == trl_dir_o[c]);

        assert_flip_while_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (xcvr_dir_o[c] != $past(xcvr_dir_o[c])) |->
                (trl_oe_n_o[c] && $past(trl_oe_n_o[c]) && busy_o[c]));

        assert_settle_before_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(trl_oe_n_o[c]) && $past(permit_i)) |->
                (since_q[c] >= SETTLE_WAIT - 1));

        assert_idle_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_o[c] |-> (trl_oe_n_o[c] == !permit_i));

        assert_busy_starts_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_o[c]) |-> trl_oe_n_o[c]);
    end

endmodule

bind cable_dir_seq cable_dir_seq_chk #(
    .NUM_CH      (NUM_CH),
    .SETTLE_WAIT (SETTLE_WAIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .permit_i   (permit_i),
    .xcvr_dir_o (xcvr_dir_o),
    .trl_dir_o  (trl_dir_o),
    .trl_oe_n_o (trl_oe_n_o),
    .busy_o     (busy_o)
);

// File: tb/tb_cable_dir_seq.sv
module tb_cable_dir_seq;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         permit_i;
    logic [N-1:0] req_input_i;
    logic [N-1:0] xcvr_dir_o, trl_dir_o, trl_oe_n_o, busy_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cable_dir_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .permit_i    (permit_i),
        .req_input_i (req_input_i),
        .xcvr_dir_o  (xcvr_dir_o),
        .trl_dir_o   (trl_dir_o),
        .trl_oe_n_o  (trl_oe_n_o),
        .busy_o      (busy_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // n rising edges, then settle at the following falling edge
    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; permit_i = 1'b1; req_input_i = '1;
        adv(3);
        chk("R4", "dir in reset", {29'd0, xcvr_dir_o}, 32'h0);
        chk("R4", "oe_n in reset", {29'd0, trl_oe_n_o}, 32'h7);
        rst_n = 1'b1;
        adv(3);
        chk("R4", "oe_n after 3 edges", {29'd0, trl_oe_n_o}, 32'h7);
        chk("R4", "busy after 3 edges", {29'd0, busy_o}, 32'h7);
        adv(1);
        chk("R4", "oe_n after 4 edges", {29'd0, trl_oe_n_o}, 32'h0);
        chk("R4", "busy after 4 edges", {29'd0, busy_o}, 32'h0);
        chk("R2", "trl dir after reset", {29'd0, trl_dir_o}, 32'h0);
    endtask

    task automatic t_switch_ch0();
        req_input_i = 3'b110;               // ch0 to output mode
        adv(2);
        chk("R5", "no reaction after edge 2", {31'd0, trl_oe_n_o[0]}, 32'h0);
        adv(1);
        chk("R5", "oe off after edge 3", {31'd0, trl_oe_n_o[0]}, 32'h1);
        chk("R9", "busy after edge 3", {29'd0, busy_o}, 32'h1);
        chk("R1", "other oe untouched", {30'd0, trl_oe_n_o[2:1]}, 32'h0);
        adv(3);
        chk("R6", "dir held at edge 6", {31'd0, xcvr_dir_o[0]}, 32'h0);
        adv(1);
        chk("R6", "xcvr dir at edge 7", {29'd0, xcvr_dir_o}, 32'h1);
        chk("R2", "trl dir at edge 7", {29'd0, trl_dir_o}, 32'h1);
        chk("R6", "oe still off at edge 7", {31'd0, trl_oe_n_o[0]}, 32'h1);
        adv(3);
        chk("R7", "oe off at edge 10", {31'd0, trl_oe_n_o[0]}, 32'h1);
        adv(1);
        chk("R7", "oe on at edge 11", {31'd0, trl_oe_n_o[0]}, 32'h0);
        chk("R9", "busy clear at edge 11", {29'd0, busy_o}, 32'h0);
    endtask

    task automatic t_permit();
        permit_i = 1'b0;
        #1;
        chk("R3", "oe forced off", {29'd0, trl_oe_n_o}, 32'h7);
        adv(2);
        chk("R3", "oe held off", {29'd0, trl_oe_n_o}, 32'h7);
        chk("R3", "dirs kept", {29'd0, xcvr_dir_o}, 32'h1);
        permit_i = 1'b1;
        #1;
        chk("R3", "oe restored", {29'd0, trl_oe_n_o}, 32'h0);
        adv(1);
    endtask

    task automatic t_retoggle_ch1();
        req_input_i[1] = 1'b0;
        adv(4);
        req_input_i[1] = 1'b1;              // revert mid-sequence
        adv(3);
        chk("R8", "first switch completes", {31'd0, xcvr_dir_o[1]}, 32'h1);
        adv(4);
        chk("R8", "no re-enable between", {31'd0, trl_oe_n_o[1]}, 32'h1);
        chk("R8", "busy between", {31'd0, busy_o[1]}, 32'h1);
        adv(4);
        chk("R8", "back to input", {31'd0, xcvr_dir_o[1]}, 32'h0);
        adv(3);
        chk("R8", "oe off at edge 18", {31'd0, trl_oe_n_o[1]}, 32'h1);
        adv(1);
        chk("R8", "oe on at edge 19", {31'd0, trl_oe_n_o[1]}, 32'h0);
        chk("R1", "ch0 untouched", {31'd0, xcvr_dir_o[0]}, 32'h1);
    endtask

    task automatic t_same_request();
        req_input_i = 3'b110;               // equals current modes
        adv(6);
        chk("R10", "no busy", {29'd0, busy_o}, 32'h0);
        chk("R10", "oe stays on", {29'd0, trl_oe_n_o}, 32'h0);
    endtask

    task automatic t_two_channels();
        req_input_i = 3'b011;               // ch0 to input, ch2 to output
        adv(7);
        chk("R1", "both flipped", {29'd0, xcvr_dir_o}, 32'h4);
        chk("R2", "trl both flipped", {29'd0, trl_dir_o}, 32'h4);
        adv(4);
        chk("R1", "both re-enabled", {29'd0, trl_oe_n_o}, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_switch_ch0();
        t_permit();
        t_retoggle_ch1();
        t_same_request();
        t_two_channels();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule